// File: doc/BRIEF.md
# APB Memory Self-Test Requester

This block is an APB requester that exercises a word-addressed memory completer on its own and reports whether it holds data. A one-cycle start pulse supplies a first and a last word index, inclusive. The block then runs two test phases over that range. In phase one, each word is written and read back at once. In phase two, the whole range is written first and then read back. Every read is compared with the value that was written to that word.

Write data comes from a 32-bit Galois LFSR that starts from a fixed seed. Phase two sets the LFSR back to the seed before its read pass, so the expected values are produced a second time and no copy of them is stored. Each transfer has no wait states and takes two cycles, a setup cycle and an enable cycle. An idle cycle follows each transfer. When the run ends, the block raises a done pulse. It keeps an error count for each phase, their sum and a pass flag, and holds them until the next start.

Top module: `apb_mem_selftest`

## Requirements
- R1: While reset is low, and in the first cycle after it, psel, penable, busy, done and pass are low and all error counts are zero.
- R2: Each transfer has a setup cycle (psel=1, penable=0) followed by an enable cycle (psel=1, penable=1). paddr, pwrite and pwdata do not change across the two cycles. Next comes one cycle with psel and penable both low.
- R3: paddr is the word index times four, so paddr[1:0]=0. Words outside the given range are never written.
- R4: Phase one visits the indices in ascending order. For each index it does a write and then, as the next transfer, a read of the same index.
- R5: Phase two writes every index in ascending order, and only then reads every index in ascending order.
- R6: The k-th write of phase one, and the k-th write of phase two, carry the LFSR value after k steps from seed 0x1ACEB00C (k counts from 0). One step is s>>1, XORed with 0x80200003 when s[0] was 1. After a run, word first+k holds that value.
- R7: prdata is sampled on the edge that ends each read's enable cycle. A mismatch with the expected value adds one to that phase's count, err_p1 or err_p2, which saturates. err_total is their sum.
- R8: pass is high after a finished run in which both counts are zero. pass and the counts hold their values until the next accepted start.
- R9: start is accepted only while busy is low. A start pulse during a run does not change the range, the timing or the result.
- R10: busy is high from the cycle after the accepting edge. done is a one-cycle pulse in the cycle where busy falls. For N words, done is high exactly 12*N-1 clock edges after the accepting edge.
- R11: If last_idx < first_idx, no transfer is issued. done pulses in the cycle after the accepting edge, the counts are zero and pass is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| first_idx | input | IDX_W | First word index, captured at start |
| last_idx | input | IDX_W | Last word index (inclusive), captured at start |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable, high in the second cycle of a transfer |
| pwrite | output | 1 | APB direction, 1 for write |
| paddr | output | ADDR_W | APB byte address |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Finished run with no mismatch |
| err_p1 | output | ERR_W | Phase-one mismatch count |
| err_p2 | output | ERR_W | Phase-two mismatch count |
| err_total | output | ERR_W+1 | Sum of both phase counts |

## Verification
The edge that samples the final read of phase two is also the edge that raises done and returns the block to idle. A mismatch on that read must therefore be counted in the same cycle that the run closes. The bench provokes this by flipping a bit in the read data of the last word of the range. It then expects err_p2 to be one and pass to be low in the cycle where done is high. A second collision is a start pulse that arrives while a run is in progress. The bench sends a start with a different range in the middle of a run and then checks that the completion cycle, the sequence of transfers and the counts all match the first request alone.

// File: rtl/apb_mem_selftest.sv
module apb_mem_selftest #(
  parameter int          IDX_W  = 10,
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter int          ERR_W  = 16,
  parameter logic [31:0] SEED   = 32'h1ACE_B00C,
  parameter logic [31:0] POLY   = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ERR_W-1:0]  err_p1,
  output logic [ERR_W-1:0]  err_p2,
  output logic [ERR_W:0]    err_total
);
  localparam int PAD_W = ADDR_W - IDX_W - 2;
  localparam logic [DATA_W-1:0] SEED_V = DATA_W'(SEED);
  localparam logic [DATA_W-1:0] POLY_V = DATA_W'(POLY);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACCESS, B_GAP} bus_t;
  typedef enum logic [1:0] {T_P1W, T_P1R, T_P2W, T_P2R} step_t;

  bus_t              bus_q;
  step_t             step_q;
  logic [IDX_W-1:0]  idx_q, lo_q, hi_q;
  logic [DATA_W-1:0] lfsr_q;
  logic [ERR_W-1:0]  err1_q, err2_q;
  logic              done_q, fin_q;

  function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY_V : '0);
  endfunction

  wire at_end  = (idx_q == hi_q);
  wire is_rd   = (step_q == T_P1R) || (step_q == T_P2R);
  wire is_wr   = !is_rd;
  wire miss    = is_rd && (prdata != lfsr_q);
  wire [IDX_W-1:0] idx_nx = idx_q + IDX_W'(1);

  assign psel      = (bus_q == B_SETUP) || (bus_q == B_ACCESS);
  assign penable   = (bus_q == B_ACCESS);
  assign pwrite    = psel && is_wr;
  assign paddr     = psel ? {{PAD_W{1'b0}}, idx_q, 2'b00} : '0;
  assign pwdata    = pwrite ? lfsr_q : '0;
  assign busy      = (bus_q != B_IDLE);
  assign done      = done_q;
  assign err_p1    = err1_q;
  assign err_p2    = err2_q;
  assign err_total = {1'b0, err1_q} + {1'b0, err2_q};
  assign pass      = fin_q && (err1_q == '0) && (err2_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= B_IDLE;
      step_q <= T_P1W;
      idx_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      lfsr_q <= SEED_V;
      err1_q <= '0;
      err2_q <= '0;
      done_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (bus_q)
        B_IDLE: if (start) begin
          lo_q   <= first_idx;
          hi_q   <= last_idx;
          idx_q  <= first_idx;
          lfsr_q <= SEED_V;
          step_q <= T_P1W;
          err1_q <= '0;
          err2_q <= '0;
          if (last_idx < first_idx) begin
            done_q <= 1'b1;
            fin_q  <= 1'b1;
          end else begin
            fin_q  <= 1'b0;
            bus_q  <= B_SETUP;
          end
        end
        B_SETUP: bus_q <= B_ACCESS;
        B_GAP:   bus_q <= B_SETUP;
        B_ACCESS: begin
          bus_q <= B_GAP;
          if (miss && step_q == T_P1R && err1_q != '1) err1_q <= err1_q + ERR_W'(1);
          if (miss && step_q == T_P2R && err2_q != '1) err2_q <= err2_q + ERR_W'(1);
          case (step_q)
            T_P1W: step_q <= T_P1R;
            T_P1R: if (at_end) begin
              step_q <= T_P2W;
              idx_q  <= lo_q;
              lfsr_q <= SEED_V;
            end else begin
              step_q <= T_P1W;
              idx_q  <= idx_nx;
              lfsr_q <= lfsr_step(lfsr_q);
            end
            T_P2W: if (at_end) begin
              step_q <= T_P2R;
              idx_q  <= lo_q;
              lfsr_q <= SEED_V;
            end else begin
              idx_q  <= idx_nx;
              lfsr_q <= lfsr_step(lfsr_q);
            end
            default: if (at_end) begin
              bus_q  <= B_IDLE;
              done_q <= 1'b1;
              fin_q  <= 1'b1;
            end else begin
              idx_q  <= idx_nx;
              lfsr_q <= lfsr_step(lfsr_q);
            end
          endcase
        end
        default: bus_q <= B_IDLE;
      endcase
    end
  end

  p_enable_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel);
  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> $past(psel && !penable));
  p_hold_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));
  p_idle_after_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |=> !psel);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !psel));
  p_pass_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !busy);
  p_counts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_total));
endmodule

// File: tb/apb_mem_selftest_bench.sv
module apb_mem_selftest_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 10;
  localparam int ERR_W = 16;
  localparam int MEMW  = 64;
  localparam logic [31:0] SEED = 32'h1ACE_B00C;
  localparam logic [31:0] POLY = 32'h8020_0003;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IDX_W-1:0] first_idx = '0, last_idx = '0;
  logic psel, penable, pwrite, busy, done, pass;
  logic [31:0] paddr, pwdata, prdata;
  logic [ERR_W-1:0] err_p1, err_p2;
  logic [ERR_W:0] err_total;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:MEMW-1];
  logic fill_req = 1'b0, fault_on = 1'b0;
  int fault_idx = 0;
  logic [5:0] amask = 6'h3f;
  int ops_n = 0, vio = 0;
  logic op_w [0:1023];
  int   op_i [0:1023];
  logic pv_sel = 0, pv_en = 0;
  logic [31:0] pv_addr = 0, pv_wd = 0;
  logic pv_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_mem_selftest #(.IDX_W(IDX_W), .ERR_W(ERR_W)) u_apb_mem_selftest (
    .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx), .last_idx(last_idx),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .busy(busy), .done(done), .pass(pass),
    .err_p1(err_p1), .err_p2(err_p2), .err_total(err_total));

  function automatic int slot(input logic [31:0] a);
    return int'(a[7:2] & amask);
  endfunction

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= 32'hDEAD_0000 | i;
    end else if (psel && penable && pwrite) mem[slot(paddr)] <= pwdata;
  end

  always_comb begin
    prdata = mem[slot(paddr)];
    if (fault_on && int'(paddr >> 2) == fault_idx) prdata = prdata ^ 32'h1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (penable && !psel) vio <= vio + 1;
      if (psel && penable && !(pv_sel && !pv_en)) vio <= vio + 1;
      if (psel && penable && (paddr != pv_addr || pwrite != pv_wr || pwdata != pv_wd)) vio <= vio + 1;
      if (psel && pv_sel && pv_en) vio <= vio + 1;
      if (psel && paddr[1:0] != 2'b00) vio <= vio + 1;
      if (psel && penable) begin
        op_w[ops_n & 1023] <= pwrite;
        op_i[ops_n & 1023] <= int'(paddr >> 2);
        ops_n <= ops_n + 1;
      end
    end
    pv_sel <= psel; pv_en <= penable; pv_addr <= paddr; pv_wr <= pwrite; pv_wd <= pwdata;
  end

  function automatic logic [31:0] lf_at(input int k);
    logic [31:0] s = SEED;
    for (int i = 0; i < k; i++) s = (s >> 1) ^ (s[0] ? POLY : 32'h0);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int f, input int l, input bit flt, input int fidx,
                     input logic [5:0] am, input bit poke, input int e1, input int e2);
    int n, cyc, ob, vb;
    bit ok;
    n = (l < f) ? 0 : l - f + 1;
    @(negedge clk);
    fault_on = flt; fault_idx = fidx; amask = am; fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    first_idx = IDX_W'(f); last_idx = IDX_W'(l); start = 1'b1;
    ob = ops_n; vb = vio;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && n > 0) chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      if (poke && cyc == 5) begin
        start = 1'b1; first_idx = 0; last_idx = 1;
      end else start = 1'b0;
    end while (!done && cyc < 20000);
    chk(cyc == ((n == 0) ? 1 : 12 * n), (n == 0) ? "R11" : "R10", "done cycle", cyc, (n == 0) ? 1 : 12 * n);
    chk(busy == 1'b0, "R10", "busy low at done", busy, 0);
    chk(err_p1 == ERR_W'(e1), "R7", "phase one count", err_p1, e1);
    chk(err_p2 == ERR_W'(e2), "R7", "phase two count", err_p2, e2);
    chk(err_total == (ERR_W+1)'(e1 + e2), "R7", "total count", err_total, e1 + e2);
    chk(pass == (e1 == 0 && e2 == 0), "R8", "pass flag", pass, (e1 == 0 && e2 == 0));
    if (poke) chk(ops_n - ob == 4 * n, "R9", "start while busy ignored", ops_n - ob, 4 * n);
    ok = (ops_n - ob == 4 * n);
    for (int k = 0; k < n && ok; k++) begin
      ok = ok && op_w[(ob + 2*k) & 1023] && op_i[(ob + 2*k) & 1023] == f + k;
      ok = ok && !op_w[(ob + 2*k + 1) & 1023] && op_i[(ob + 2*k + 1) & 1023] == f + k;
    end
    chk(ok, "R4", "phase one order", ops_n - ob, 4 * n);
    ok = (ops_n - ob == 4 * n);
    for (int k = 0; k < n && ok; k++) begin
      ok = ok && op_w[(ob + 2*n + k) & 1023] && op_i[(ob + 2*n + k) & 1023] == f + k;
      ok = ok && !op_w[(ob + 3*n + k) & 1023] && op_i[(ob + 3*n + k) & 1023] == f + k;
    end
    chk(ok, "R5", "phase two order", ops_n - ob, 4 * n);
    chk(vio == vb, "R2", "transfer shape", vio - vb, 0);
    if (am == 6'h3f) begin
      ok = 1'b1;
      for (int i = 0; i < MEMW; i++) begin
        if (i >= f && i <= l) ok = ok && mem[i] == lf_at(i - f);
        else ok = ok && mem[i] == (32'hDEAD_0000 | i);
      end
      chk(ok, "R6", "memory image", mem[f], lf_at(0));
      chk(ok, "R3", "words outside range", {31'b0, ok}, 1);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(err_total == (ERR_W+1)'(e1 + e2) && pass == (e1 == 0 && e2 == 0), "R8", "results held",
        err_total, e1 + e2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f, l, fi, e;
    bit fl;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!psel && !penable && !busy && !done && !pass && err_total == 0, "R1", "in reset",
        {psel, penable, busy, done, pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!psel && !penable && !busy && !done && !pass && err_total == 0, "R1", "after reset",
        {psel, penable, busy, done, pass}, 0);
    run(0, 0, 0, 0, 6'h3f, 0, 0, 0);
    run(3, 10, 0, 0, 6'h3f, 0, 0, 0);
    run(4, 9, 1, 9, 6'h3f, 0, 1, 1);
    run(2, 6, 1, 2, 6'h3f, 0, 1, 1);
    run(0, 7, 0, 0, 6'h03, 0, 0, 4);
    run(12, 20, 0, 0, 6'h3f, 1, 0, 0);
    run(8, 5, 0, 0, 6'h3f, 0, 0, 0);
    run(0, 63, 0, 0, 6'h3f, 0, 0, 0);
    for (int t = 0; t < 14; t++) begin
      f  = int'($urandom_range(0, 40));
      l  = f + int'($urandom_range(0, 22));
      fl = 1'($urandom_range(0, 1));
      fi = int'($urandom_range(0, 63));
      e  = (fl && fi >= f && fi <= l) ? 1 : 0;
      run(f, l, fl, fi, 6'h3f, (t % 4) == 1, e, e);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule